// File: doc/BRIEF.md
# Flash Word-Program and Page-Erase Sequencer

This block sequences the two operations that change an on-chip flash array: programming one 16-bit word and erasing one 1 KB page. The array sits inside the block as a register array of 16-bit words, sized by a page-count parameter of 8, 16 or 32 pages of 512 words each. Software reaches the block through four byte-wide registers, chosen by a 2-bit select: a low address byte, a high address byte, a control register and a data register. Writes from a processor or a DMA engine both arrive as one byte write strobe.

Programming has AND semantics: a bit can only go from 1 to 0, so the stored word becomes old AND new. After the write-enable bit is set, the data register takes byte pairs, low byte first. Each completed pair commits one word at the current word address. The address then steps forward so that blocks of words can be streamed in. An erase sets every bit of the page that the high address byte selects. Both operations hold a busy flag for a number of cycles set by a parameter. A combinational word read port lets the array contents be inspected.

Top module: `flash_ctl`

## Requirements
- R1: After reset, busy and write_armed are 0, word_addr is 0, and every array word reads 16'hFFFF.
- R2: reg_sel 0 writes word_addr[7:0] and reg_sel 1 writes word_addr[13:8] from reg_wdata[5:0], ignoring reg_wdata[7:6]. The array word used is word_addr modulo the array size in words.
- R3: A control write (reg_sel 2) sets write_armed to reg_wdata[1] when reg_wdata[0] is 0. Every accepted control write throws away a low data byte that is waiting for its pair.
- R4: While armed, data writes (reg_sel 3) pair up, low byte first. The second byte commits {high, low} to the addressed word, and a lone byte commits nothing.
- R5: A commit stores old AND new, so a 1 written over a stored 0 has no effect.
- R6: After each commit, word_addr becomes the next word index. After the last word of the array it wraps to 0.
- R7: After a commit, busy is high for exactly WRITE_CYCLES cycles and then clears by itself.
- R8: A control write with bit 0 set erases page word_addr[13:9]. All 512 words of that page become 16'hFFFF, other pages keep their contents, and busy is high for exactly ERASE_CYCLES cycles.
- R9: A control write with bits 0 and 1 both set runs only the erase and leaves write_armed at 0.
- R10: An erase request whose page index is NUM_PAGES or more is ignored, and busy stays 0.
- R11: While busy is high, every register write is ignored. This covers address bytes, data bytes and control.
- R12: Data writes while write_armed is 0 change neither the array nor word_addr, and they start no operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register byte write strobe |
| reg_sel | input | 2 | Register select: 0 address low, 1 address high, 2 control, 3 data |
| reg_wdata | input | 8 | Byte written |
| busy | output | 1 | A timed program or erase is in progress |
| write_armed | output | 1 | Program mode enabled |
| word_addr | output | 14 | Current 14-bit word address |
| rd_idx | input | $clog2(NUM_PAGES*512) | Array word index to inspect |
| rd_word | output | 16 | Array word at rd_idx |

## Verification
The hardest case to reach from the ports is a register write that lands inside a busy window. The sharpest form is a data byte arriving just after a commit: if the block wrongly accepted it, it would pair with a later byte and commit on its own. The stimulus writes an address byte and a data byte in the two cycles right after a commit edge. Once busy clears, it sends a single data byte and expects no commit. A second hard case is a half-written word that a control write discards, so the next pair must not pick up the stale low byte.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;

   localparam int WORD_ADDR_W = 14;
   localparam int PAGE_WORDS  = 512;
   localparam int PAGE_OFS_W  = 9;
   localparam int CTRL_ERASE  = 0;
   localparam int CTRL_WRITE  = 1;

   typedef enum logic [1:0] {
      SEL_ADDR_LO = 2'd0,
      SEL_ADDR_HI = 2'd1,
      SEL_CTRL    = 2'd2,
      SEL_DATA    = 2'd3
   } fc_sel_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PROG  = 2'd1,
      ST_ERASE = 2'd2
   } fc_state_e;

endpackage

// File: rtl/flash_ctl_array.sv
module flash_ctl_array #(
   parameter int WORDS = 4096,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             fill,
   input  logic [IDX_W-1:0] idx,
   input  logic [15:0]      wdata,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [15:0]      rd_data
);

   logic [15:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
      end else if (we) begin
         if (fill) mem[idx] <= 16'hFFFF;
         else      mem[idx] <= mem[idx] & wdata;
      end
   end

   assign rd_data = mem[rd_idx];

endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
   import flash_ctl_pkg::*;
#(
   parameter int NUM_PAGES = 8,
   localparam int WORDS = NUM_PAGES * PAGE_WORDS,
   localparam int IDX_W = $clog2(WORDS),
   localparam int PG_W  = $clog2(NUM_PAGES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [1:0]             reg_sel,
   input  logic [7:0]             reg_wdata,
   input  logic                   busy,
   output logic [WORD_ADDR_W-1:0] word_addr,
   output logic                   armed,
   output logic                   cmd_prog,
   output logic [IDX_W-1:0]       prog_idx,
   output logic [15:0]            prog_word,
   output logic                   cmd_erase,
   output logic [PG_W-1:0]        erase_page
);

   logic [WORD_ADDR_W-1:0] addr_q;
   logic                   armed_q;
   logic                   lo_valid_q;
   logic [7:0]             lo_q;
   logic                   accept;
   logic                   ctrl_hit;
   logic                   data_hit;
   logic [5:0]             page_field;
   logic                   page_ok;
   logic [IDX_W-1:0]       idx_inc;
   logic [WORD_ADDR_W-1:0] next_addr;

   assign accept     = reg_we && !busy;
   assign ctrl_hit   = accept && (fc_sel_e'(reg_sel) == SEL_CTRL);
   assign data_hit   = accept && (fc_sel_e'(reg_sel) == SEL_DATA) && armed_q;
   assign page_field = {1'b0, addr_q[WORD_ADDR_W-1:PAGE_OFS_W]};
   assign page_ok    = page_field < 6'(NUM_PAGES);

   assign cmd_erase  = ctrl_hit && reg_wdata[CTRL_ERASE] && page_ok;
   assign cmd_prog   = data_hit && lo_valid_q;
   assign prog_idx   = addr_q[IDX_W-1:0];
   assign prog_word  = {reg_wdata, lo_q};
   assign erase_page = addr_q[PAGE_OFS_W +: PG_W];
   assign idx_inc    = prog_idx + 1'b1;

   generate
      if (IDX_W < WORD_ADDR_W) begin : g_pad
         assign next_addr = {{(WORD_ADDR_W-IDX_W){1'b0}}, idx_inc};
      end else begin : g_full
         assign next_addr = idx_inc;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q     <= '0;
         armed_q    <= 1'b0;
         lo_valid_q <= 1'b0;
         lo_q       <= '0;
      end else if (accept) begin
         case (fc_sel_e'(reg_sel))
            SEL_ADDR_LO: addr_q[7:0] <= reg_wdata;
            SEL_ADDR_HI: addr_q[WORD_ADDR_W-1:8] <= reg_wdata[5:0];
            SEL_CTRL: begin
               armed_q    <= reg_wdata[CTRL_WRITE] && !reg_wdata[CTRL_ERASE];
               lo_valid_q <= 1'b0;
            end
            default: begin
               if (armed_q) begin
                  if (!lo_valid_q) begin
                     lo_q       <= reg_wdata;
                     lo_valid_q <= 1'b1;
                  end else begin
                     lo_valid_q <= 1'b0;
                     addr_q     <= next_addr;
                  end
               end
            end
         endcase
      end
   end

   assign word_addr = addr_q;
   assign armed     = armed_q;

   // R11: no register state moves while an operation is timed
   p_addr_frozen_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));

   // R9: an erase request never leaves program mode enabled
   p_erase_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_erase |=> !armed_q);

   // R12: data bytes have no effect unless armed
   p_unarmed_no_commit_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !cmd_prog);

endmodule

// File: rtl/flash_ctl_seq.sv
module flash_ctl_seq
   import flash_ctl_pkg::*;
#(
   parameter int NUM_PAGES    = 8,
   parameter int WRITE_CYCLES = 4,
   parameter int ERASE_CYCLES = 520,
   localparam int WORDS = NUM_PAGES * PAGE_WORDS,
   localparam int IDX_W = $clog2(WORDS),
   localparam int PG_W  = $clog2(NUM_PAGES),
   localparam int CNT_W = $clog2(ERASE_CYCLES + 1),
   localparam int PTR_W = PAGE_OFS_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_prog,
   input  logic [IDX_W-1:0] prog_idx,
   input  logic [15:0]      prog_word,
   input  logic             cmd_erase,
   input  logic [PG_W-1:0]  erase_page,
   output logic             busy,
   output logic             mem_we,
   output logic             mem_fill,
   output logic [IDX_W-1:0] mem_idx,
   output logic [15:0]      mem_wdata
);

   fc_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] ptr_q;
   logic [PG_W-1:0]  page_q;
   logic             filling;

   assign filling = (state_q == ST_ERASE) && !ptr_q[PTR_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         ptr_q   <= '0;
         page_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (cmd_erase) begin
                  state_q <= ST_ERASE;
                  cnt_q   <= CNT_W'(ERASE_CYCLES - 1);
                  ptr_q   <= '0;
                  page_q  <= erase_page;
               end else if (cmd_prog) begin
                  state_q <= ST_PROG;
                  cnt_q   <= CNT_W'(WRITE_CYCLES - 1);
               end
            end
            default: begin
               if (filling) ptr_q <= ptr_q + 1'b1;
               if (cnt_q == '0) state_q <= ST_IDLE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign mem_we    = cmd_prog || filling;
   assign mem_fill  = !cmd_prog;
   assign mem_idx   = cmd_prog ? prog_idx : {page_q, ptr_q[PAGE_OFS_W-1:0]};
   assign mem_wdata = prog_word;

   // R7: a commit always opens a busy window
   p_commit_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_prog |=> busy);

   // R7: busy never rises without a request
   p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_prog && !cmd_erase) |=> !busy);

   // R9: program and erase requests never coincide
   p_one_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_prog, cmd_erase}));

   // R11: requests only arrive while idle
   p_no_request_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(cmd_prog || cmd_erase));

   // R8: the fill walk finishes before busy drops
   p_fill_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && $past(state_q == ST_ERASE) |-> ptr_q[PTR_W-1]);

endmodule

// File: rtl/flash_ctl.sv
module flash_ctl
   import flash_ctl_pkg::*;
#(
   parameter int NUM_PAGES    = 8,
   parameter int WRITE_CYCLES = 4,
   parameter int ERASE_CYCLES = 520,
   localparam int WORDS = NUM_PAGES * PAGE_WORDS,
   localparam int IDX_W = $clog2(WORDS),
   localparam int PG_W  = $clog2(NUM_PAGES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_we,
   input  logic [1:0]             reg_sel,
   input  logic [7:0]             reg_wdata,
   output logic                   busy,
   output logic                   write_armed,
   output logic [WORD_ADDR_W-1:0] word_addr,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic [15:0]            rd_word
);

   generate
      if (!(NUM_PAGES == 8 || NUM_PAGES == 16 || NUM_PAGES == 32)) begin : g_bad_pages
         $error("flash_ctl: NUM_PAGES must be 8, 16 or 32");
      end
      if (WRITE_CYCLES < 1) begin : g_bad_write
         $error("flash_ctl: WRITE_CYCLES must be at least 1");
      end
      if (ERASE_CYCLES < PAGE_WORDS || ERASE_CYCLES < WRITE_CYCLES) begin : g_bad_erase
         $error("flash_ctl: ERASE_CYCLES must cover one page fill and the write time");
      end
   endgenerate

   logic             cmd_prog;
   logic             cmd_erase;
   logic [IDX_W-1:0] prog_idx;
   logic [15:0]      prog_word;
   logic [PG_W-1:0]  erase_page;
   logic             mem_we;
   logic             mem_fill;
   logic [IDX_W-1:0] mem_idx;
   logic [15:0]      mem_wdata;

   flash_ctl_regs #(.NUM_PAGES(NUM_PAGES)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .reg_sel    (reg_sel),
      .reg_wdata  (reg_wdata),
      .busy       (busy),
      .word_addr  (word_addr),
      .armed      (write_armed),
      .cmd_prog   (cmd_prog),
      .prog_idx   (prog_idx),
      .prog_word  (prog_word),
      .cmd_erase  (cmd_erase),
      .erase_page (erase_page)
   );

   flash_ctl_seq #(
      .NUM_PAGES    (NUM_PAGES),
      .WRITE_CYCLES (WRITE_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_prog   (cmd_prog),
      .prog_idx   (prog_idx),
      .prog_word  (prog_word),
      .cmd_erase  (cmd_erase),
      .erase_page (erase_page),
      .busy       (busy),
      .mem_we     (mem_we),
      .mem_fill   (mem_fill),
      .mem_idx    (mem_idx),
      .mem_wdata  (mem_wdata)
   );

   flash_ctl_array #(.WORDS(WORDS)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (mem_we),
      .fill    (mem_fill),
      .idx     (mem_idx),
      .wdata   (mem_wdata),
      .rd_idx  (rd_idx),
      .rd_data (rd_word)
   );

   // R10: an out-of-range page request leaves the block idle
   p_bad_page_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel == 2'd2 && reg_wdata[CTRL_ERASE] && !reg_wdata[CTRL_WRITE] && !busy
       && ({1'b0, word_addr[WORD_ADDR_W-1:PAGE_OFS_W]} >= 6'(NUM_PAGES))) |=> !busy);

endmodule

// File: tb/tb_flash_ctl.sv
`timescale 1ns/1ps
module tb_flash_ctl;

   localparam int NP    = 8;
   localparam int WCYC  = 4;
   localparam int ECYC  = 520;
   localparam int WORDS = NP * 512;
   localparam int IW    = $clog2(WORDS);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [1:0]    reg_sel = '0;
   logic [7:0]    reg_wdata = '0;
   logic          busy;
   logic          write_armed;
   logic [13:0]   word_addr;
   logic [IW-1:0] rd_idx = '0;
   logic [15:0]   rd_word;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   typedef struct {
      int          idx;
      logic [15:0] val;
      string       tag;
   } sb_item_t;

   sb_item_t    sb_q[$];
   logic [15:0] model [WORDS];
   int          exp_addr = 0;

   always #2.5 clk = ~clk;

   flash_ctl #(.NUM_PAGES(NP), .WRITE_CYCLES(WCYC), .ERASE_CYCLES(ECYC)) dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .busy(busy), .write_armed(write_armed),
      .word_addr(word_addr), .rd_idx(rd_idx), .rd_word(rd_word)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected array words and compares them at the read port
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         rd_idx = IW'(it.idx);
         #1;
         check(it.tag, int'(rd_word), int'(it.val));
      end
   end

   task automatic expect_word(input int idx, input string tag);
      sb_item_t it;
      it.idx = idx;
      it.val = model[idx];
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic drain();
      while (sb_q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1;
      reg_sel = sel;
      reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic prog(input logic [7:0] lo, input logic [7:0] hi);
      wr(2'd3, lo);
      wr(2'd3, hi);
      model[exp_addr] = model[exp_addr] & {hi, lo};
      exp_addr = (exp_addr + 1) % WORDS;
      wait_idle();
   endtask

   task automatic fill_model(input int page);
      for (int i = 0; i < 512; i++) model[page * 512 + i] = 16'hFFFF;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n;
      for (int i = 0; i < WORDS; i++) model[i] = 16'hFFFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", int'(busy), 0);
      check("R1 armed", int'(write_armed), 0);
      check("R1 addr", int'(word_addr), 0);
      expect_word(0, "R1 word0");
      expect_word(WORDS - 1, "R1 last word");
      expect_word(1234, "R1 mid word");
      drain();

      // R2, R3, R4, R7: first word program
      wr(2'd0, 8'h10);
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h02);
      exp_addr = 'h10;
      check("R3 armed", int'(write_armed), 1);
      check("R2 addr", int'(word_addr), 'h10);
      wr(2'd3, 8'h34);
      check("R4 lone byte no commit", int'(busy), 0);
      wr(2'd3, 8'h12);
      model['h10] = model['h10] & 16'h1234;
      exp_addr = 'h11;
      count_busy(n);
      check("R7 write busy cycles", n, WCYC);
      check("R6 addr step", int'(word_addr), 'h11);
      prog(8'h0F, 8'hF0);
      wr(2'd0, 8'h11);
      exp_addr = 'h11;
      prog(8'hF0, 8'hFF);           // R5: F00F & FFF0 -> F000
      expect_word('h10, "R4 word 0x10");
      expect_word('h11, "R5 and semantics");
      check("R5 model value", int'(model['h11]), 'hF000);
      drain();

      // R2 upper bits ignored, R6 wrap
      wr(2'd1, 8'hCF);
      wr(2'd0, 8'hFF);
      check("R2 high byte masked", int'(word_addr), 'h0FFF);
      exp_addr = WORDS - 1;
      prog(8'hAA, 8'hAA);
      check("R6 wrap to zero", int'(word_addr), 0);
      prog(8'h55, 8'h55);
      check("R6 after wrap", int'(word_addr), 1);
      expect_word(WORDS - 1, "R6 last word");
      expect_word(0, "R6 wrapped word");
      drain();

      // R11: writes during busy ignored
      wr(2'd0, 8'h40);
      wr(2'd1, 8'h00);
      exp_addr = 'h40;
      wr(2'd3, 8'h11);
      wr(2'd3, 8'h22);
      model['h40] = model['h40] & 16'h2211;
      wr(2'd0, 8'h77);
      wr(2'd3, 8'h99);
      wait_idle();
      check("R11 addr untouched", int'(word_addr), 'h41);
      wr(2'd3, 8'h01);
      check("R11 busy-time byte dropped", int'(busy), 0);
      wr(2'd3, 8'h02);
      model['h41] = model['h41] & 16'h0201;
      wait_idle();
      expect_word('h40, "R11 word 0x40");
      expect_word('h41, "R11 word 0x41");
      drain();

      // R12 and R3 disarm
      wr(2'd2, 8'h00);
      check("R3 disarm", int'(write_armed), 0);
      wr(2'd3, 8'h00);
      wr(2'd3, 8'h00);
      check("R12 no busy", int'(busy), 0);
      check("R12 addr held", int'(word_addr), 'h42);
      expect_word('h42, "R12 word untouched");
      drain();

      // R3: control write discards pending low byte
      wr(2'd2, 8'h02);
      wr(2'd3, 8'h00);
      wr(2'd2, 8'h02);
      exp_addr = 'h42;
      prog(8'hEE, 8'hDD);
      expect_word('h42, "R3 pending discarded");
      drain();

      // R8 erase page 0
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h01);
      count_busy(n);
      check("R8 erase busy cycles", n, ECYC);
      check("R8 erase disarms", int'(write_armed), 0);
      fill_model(0);
      expect_word('h10, "R8 erased 0x10");
      expect_word('h11, "R8 erased 0x11");
      expect_word('h42, "R8 erased 0x42");
      expect_word(511, "R8 erased page end");
      expect_word(WORDS - 1, "R8 other page kept");
      drain();

      // R9 erase priority, page 7
      wr(2'd1, 8'h0E);
      wr(2'd2, 8'h03);
      count_busy(n);
      check("R9 erase cycles", n, ECYC);
      check("R9 not armed", int'(write_armed), 0);
      fill_model(7);
      expect_word(WORDS - 1, "R9 page 7 erased");
      drain();

      // R10 invalid page
      wr(2'd1, 8'h10);
      wr(2'd2, 8'h01);
      check("R10 page 8 ignored", int'(busy), 0);
      wr(2'd1, 8'h3E);
      wr(2'd2, 8'h01);
      check("R10 page 31 ignored", int'(busy), 0);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule